// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block sits between a synchronous host and an external asynchronous static memory of 512K bytes. The host sees a single-word request port, where a valid/ready handshake carries the operation, the address and the write byte, and a separate read-return path that gives a one-cycle valid pulse. The memory side has a 19-bit address, a bidirectional 8-bit data bus and three active-low strobes: select, output enable and write enable.

The memory has no clock, so every access has to satisfy its analog timing limits. Two parameters set these limits: the speed grade (0 to 3, for 17, 20, 25 or 35 ns cycle parts) and the clock period in nanoseconds. At elaboration the block turns the access time and the output-float time into whole cycle counts, rounding up. The read window, the write strobe width and the bus-release gap after a read all follow from these counts. The controller drives the data pins only while it writes. After each read it leaves the select and output-enable strobes high long enough for the memory outputs to float before any write can begin.

Top module: `sram_ctrl`

## Requirements
- R1: During and directly after reset, all three strobes are high, `req_ready` is 1 and `rd_valid` is 0.
- R2: A read holds select and output enable low and write enable high for exactly RD_CYC = ceil(t_cycle / CLK_NS) consecutive cycles. t_cycle is 17, 20, 25 or 35 ns for GRADE 0..3.
- R3: Read data is sampled in the last cycle of the read window. It appears on `rd_data` together with a single-cycle `rd_valid` pulse in the first cycle after output enable goes high, and there is exactly one pulse per read.
- R4: A write holds select and write enable low and output enable high for exactly WR_CYC = RD_CYC cycles, while it drives the request's byte on the data pins.
- R5: For one cycle after write enable goes high, the address and the data pins keep the values of the write window.
- R6: After output enable goes high at the end of a read, write enable stays high for at least HZ_CYC = ceil(t_float / CLK_NS) cycles. t_float is 8, 8, 10 or 12 ns for GRADE 0..3.
- R7: The address of the request is on the address pins from the first cycle in which select is low, and it does not change while select stays low.
- R8: `req_ready` is high only while the controller is idle. A request raised while `req_ready` is low is ignored and causes no memory access.
- R9: The controller drives the data pins only in the write window and the single hold cycle after it. A read issued right after a write returns the memory's data.
- R10: Whenever the controller is idle, select, output enable and write enable are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle read-return pulse |
| rd_data | output | 8 | Read byte, valid with `rd_valid` |
| mem_addr | output | 19 | Memory address pins |
| mem_dq | inout | 8 | Memory data pins |
| mem_ce_n | output | 1 | Memory select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |

## Verification
The strobes are registered, so they change at the clock edge that accepts a request. `req_ready` falls at that same edge. The bench therefore samples on falling edges and expects the strobes to move one sample after the request is presented. It measures the low runs of output enable and write enable and compares them with RD_CYC and WR_CYC, which it computes itself from the grade tables. `rd_valid` is due in the same sample in which output enable is first seen high again, and the bench checks the returned byte there against its own copy of the memory. The release gap before a write and the one-cycle hold after write enable rises are checked by counting samples relative to those strobe edges.

// File: rtl/sram_pkg.sv
`timescale 1ns/1ps
package sram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_RREC,
      ST_WRITE,
      ST_WHOLD
   } sram_st_t;

   // cycle / access time of the part, in ns
   function automatic int grade_cycle_ns(input int grade);
      case (grade)
         0:       return 17;
         1:       return 20;
         2:       return 25;
         default: return 35;
      endcase
   endfunction

   // time for outputs to float after a strobe rises, in ns
   function automatic int grade_float_ns(input int grade);
      case (grade)
         0:       return 8;
         1:       return 8;
         2:       return 10;
         default: return 12;
      endcase
   endfunction

   function automatic int ns_to_cycles(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/sram_seq.sv
`timescale 1ns/1ps
module sram_seq
   import sram_pkg::*;
#(
   parameter int GRADE  = 0,
   parameter int CLK_NS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_we,
   output logic req_ready,
   output logic load,
   output logic capture,
   output logic drive,
   output logic rd_valid,
   output logic ce_n,
   output logic oe_n,
   output logic we_n
);

   localparam int RD_CYC = ns_to_cycles(grade_cycle_ns(GRADE), CLK_NS);
   localparam int WR_CYC = RD_CYC;
   localparam int HZ_CYC = ns_to_cycles(grade_float_ns(GRADE), CLK_NS);
   localparam int MAX_C  = max3(RD_CYC, WR_CYC, HZ_CYC);
   localparam int CW     = $clog2(MAX_C + 1);

   generate
      if (GRADE < 0 || GRADE > 3) begin : g_bad_grade
         $error("sram_seq: GRADE must be 0..3");
      end
      if (CLK_NS < 1) begin : g_bad_clk
         $error("sram_seq: CLK_NS must be positive");
      end
   endgenerate

   sram_st_t        state, nxt;
   logic [CW-1:0]   cnt, cnt_nxt;

   always_comb begin
      nxt     = state;
      cnt_nxt = cnt;
      case (state)
         ST_IDLE: begin
            if (req_valid) begin
               if (req_we) begin
                  nxt     = ST_WRITE;
                  cnt_nxt = CW'(WR_CYC - 1);
               end else begin
                  nxt     = ST_READ;
                  cnt_nxt = CW'(RD_CYC - 1);
               end
            end
         end
         ST_READ: begin
            if (cnt == '0) begin
               nxt     = ST_RREC;
               cnt_nxt = CW'(HZ_CYC - 1);
            end else begin
               cnt_nxt = cnt - 1'b1;
            end
         end
         ST_RREC: begin
            if (cnt == '0) nxt = ST_IDLE;
            else           cnt_nxt = cnt - 1'b1;
         end
         ST_WRITE: begin
            if (cnt == '0) nxt = ST_WHOLD;
            else           cnt_nxt = cnt - 1'b1;
         end
         ST_WHOLD: nxt = ST_IDLE;
         default:  nxt = ST_IDLE;
      endcase
   end

   assign req_ready = (state == ST_IDLE);
   assign load      = req_valid && req_ready;
   assign capture   = (state == ST_READ) && (cnt == '0);
   assign drive     = (state == ST_WRITE) || (state == ST_WHOLD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         ce_n     <= 1'b1;
         oe_n     <= 1'b1;
         we_n     <= 1'b1;
         rd_valid <= 1'b0;
      end else begin
         state    <= nxt;
         cnt      <= cnt_nxt;
         ce_n     <= !((nxt == ST_READ) || (nxt == ST_WRITE));
         oe_n     <= !(nxt == ST_READ);
         we_n     <= !(nxt == ST_WRITE);
         rd_valid <= capture;
      end
   end

   // ---------------- checks ----------------
   localparam int RW = $clog2(MAX_C + 2) + 1;
   logic [RW-1:0] oe_run, we_run, gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_run <= '0;
         we_run <= '0;
         gap    <= RW'(HZ_CYC);
      end else begin
         oe_run <= oe_n ? '0 : oe_run + 1'b1;
         we_run <= we_n ? '0 : we_run + 1'b1;
         if (!oe_n)                gap <= '0;
         else if (gap < RW'(HZ_CYC)) gap <= gap + 1'b1;
      end
   end

   AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_n) |-> (oe_run == RW'(RD_CYC)));                       // R2
   AST_WR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(we_n) |-> (we_run == RW'(WR_CYC)));                       // R4
   AST_WR_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> oe_n);                                                // R4
   AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(we_n) |-> (gap >= RW'(HZ_CYC)));                          // R6
   AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);                                        // R3
   AST_PULSE_AFTER_RD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $rose(oe_n));                               // R3
   AST_SELECT_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_n || !we_n) |-> !ce_n);                                    // R10
   AST_READY_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (ce_n && oe_n && we_n));                          // R8

endmodule

// File: rtl/sram_dpath.sv
`timescale 1ns/1ps
module sram_dpath #(
   parameter int AW = 19,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          capture,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic [DW-1:0] dq_in,
   output logic [AW-1:0] addr_q,
   output logic [DW-1:0] wdata_q,
   output logic [DW-1:0] rdata_q
);

   generate
      if (AW < 1 || DW < 1) begin : g_bad_width
         $error("sram_dpath: widths must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (load) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
         end
         if (capture) rdata_q <= dq_in;
      end
   end

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl #(
   parameter int GRADE  = 0,
   parameter int CLK_NS = 8,
   parameter int AW     = 19,
   parameter int DW     = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic          req_we,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [AW-1:0] mem_addr,
   inout  wire  [DW-1:0] mem_dq,
   output logic          mem_ce_n,
   output logic          mem_oe_n,
   output logic          mem_we_n
);

   logic          load, capture, drive;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] dq_in;

   sram_seq #(.GRADE(GRADE), .CLK_NS(CLK_NS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_we    (req_we),
      .req_ready (req_ready),
      .load      (load),
      .capture   (capture),
      .drive     (drive),
      .rd_valid  (rd_valid),
      .ce_n      (mem_ce_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n)
   );

   sram_dpath #(.AW(AW), .DW(DW)) u_dp (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .dq_in     (dq_in),
      .addr_q    (mem_addr),
      .wdata_q   (wdata_q),
      .rdata_q   (rd_data)
   );

   assign dq_in = mem_dq;

   generate
      for (genvar i = 0; i < DW; i++) begin : g_dq
         assign mem_dq[i] = drive ? wdata_q[i] : 1'bz;
      end
   endgenerate

   AST_DRIVE_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      drive |-> mem_oe_n);                                            // R9
   AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));         // R7
   AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> (drive && $stable(mem_addr)));              // R5

endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;

   localparam int CK     = 8;
   localparam int T_CYC  = 17;   // grade 0
   localparam int T_FLT  = 8;
   localparam int EXP_RD = (T_CYC + CK - 1) / CK;
   localparam int EXP_HZ = (T_FLT + CK - 1) / CK;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_we = 1'b0;
   logic [18:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        req_ready, rd_valid;
   logic [7:0]  rd_data;
   logic [18:0] mem_addr;
   wire  [7:0]  mem_dq;
   logic        mem_ce_n, mem_oe_n, mem_we_n;

   always #4 clk = ~clk;

   sram_ctrl #(.GRADE(0), .CLK_NS(CK)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_dq(mem_dq), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n)
   );

   // memory model: 256 bytes indexed by the low address byte
   logic [7:0] model [256];
   logic [7:0] shadow [256];
   assign mem_dq = (!mem_ce_n && !mem_oe_n && mem_we_n) ? model[mem_addr[7:0]] : 8'hzz;

   int   nvec = 0, nfail = 0;
   bit   done = 1'b0;
   bit   mon_on = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // expected values set by the driver
   logic [18:0] cur_addr;
   logic [7:0]  exp_wd, exp_rd;
   int          n_wr_commit = 0, n_rd_ret = 0;

   // monitor state
   int          oe_run = 0, we_run = 0, gap = 100;
   bit          prev_oe = 1'b1, prev_we = 1'b1, addr_moved = 1'b0;
   logic [18:0] pend_a, run_a;
   logic [7:0]  pend_d;

   always @(negedge clk) begin
      if (mon_on) begin
         // read window
         if (!mem_oe_n) begin
            if (oe_run == 0) begin
               run_a = mem_addr;
               chk(mem_addr == cur_addr, "R7 read addr", int'(mem_addr), int'(cur_addr));
            end else if (mem_addr != run_a) addr_moved = 1'b1;
            oe_run++;
            if (!mem_we_n || mem_ce_n) chk(1'b0, "R2 strobe mix", {mem_ce_n, mem_we_n}, 2'b01);
         end else if (oe_run != 0) begin
            chk(oe_run == EXP_RD, "R2 read window", oe_run, EXP_RD);
            chk(!addr_moved, "R7 addr stable", int'(addr_moved), 0);
            addr_moved = 1'b0;
            oe_run = 0;
         end
         // release gap
         if (!mem_oe_n) gap = 0; else if (gap < 100) gap++;
         if (!mem_we_n && prev_we)
            chk(gap >= EXP_HZ, "R6 turnaround", gap, EXP_HZ);
         // write window
         if (!mem_we_n) begin
            we_run++;
            pend_a = mem_addr;
            pend_d = mem_dq;
            if (mem_ce_n || !mem_oe_n) chk(1'b0, "R4 strobe mix", {mem_ce_n, mem_oe_n}, 2'b01);
         end else if (!prev_we) begin
            chk(we_run == EXP_RD, "R4 write window", we_run, EXP_RD);
            chk(pend_d == exp_wd, "R4 write data", int'(pend_d), int'(exp_wd));
            chk(pend_a == cur_addr, "R7 write addr", int'(pend_a), int'(cur_addr));
            chk(mem_addr == pend_a && mem_dq == pend_d, "R5 hold",
                int'({mem_addr, mem_dq}), int'({pend_a, pend_d}));
            model[pend_a[7:0]] = pend_d;
            n_wr_commit++;
            we_run = 0;
         end
         // read return
         if (rd_valid) begin
            n_rd_ret++;
            chk(rd_data == exp_rd, "R3 read data", int'(rd_data), int'(exp_rd));
            chk(mem_oe_n && !prev_oe, "R3 pulse timing", int'({prev_oe, mem_oe_n}), 2'b01);
         end
         prev_oe = mem_oe_n;
         prev_we = mem_we_n;
      end
   end

   task automatic do_op(input bit we, input logic [18:0] a, input logic [7:0] d, input bit poke_busy);
      while (!req_ready) @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n, "R10 idle strobes",
          int'({mem_ce_n, mem_oe_n, mem_we_n}), 3'b111);
      cur_addr = a;
      if (we) begin
         exp_wd = d;
         shadow[a[7:0]] = d;
      end else begin
         exp_rd = shadow[a[7:0]];
      end
      req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
      @(negedge clk);
      chk(!req_ready, "R8 busy", int'(req_ready), 0);
      if (poke_busy) begin
         // request while busy must be ignored
         req_we = 1'b1; req_addr = a ^ 19'h000ff; req_wdata = 8'h5a;
         @(negedge clk);
      end
      req_valid = 1'b0;
   endtask

   function automatic logic [18:0] addr_of(input int k);
      return {11'(k * 37 + 5), 8'(k)};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         nvec++;
         $display("FAIL watchdog expired");
         $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 256; i++) begin
         model[i]  = 8'(i ^ 8'hc3);
         shadow[i] = 8'(i ^ 8'hc3);
      end
      repeat (2) @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset",
          int'({mem_ce_n, mem_oe_n, mem_we_n}), 3'b111);
      chk(req_ready && !rd_valid, "R1 handshake in reset", int'({req_ready, rd_valid}), 2'b10);
      rst_n = 1'b1;
      @(negedge clk);
      chk(mem_ce_n && mem_oe_n && mem_we_n && req_ready && !rd_valid, "R1 after reset",
          int'({mem_ce_n, mem_oe_n, mem_we_n, req_ready, rd_valid}), 5'b11110);
      mon_on = 1'b1;
      // reads of initial contents
      for (int k = 0; k < 16; k++) do_op(1'b0, addr_of(k), 8'h00, 1'b0);
      // write every low-address byte
      for (int k = 0; k < 256; k++) do_op(1'b1, addr_of(k), 8'(k * 7 + 3), 1'b0);
      // read them all back
      for (int k = 0; k < 256; k++) do_op(1'b0, addr_of(k), 8'h00, 1'b0);
      // write followed at once by a read of another address (R9)
      for (int k = 0; k < 16; k++) begin
         do_op(1'b1, addr_of(k), 8'(8'hf0 - k), 1'b0);
         do_op(1'b0, addr_of(k + 100), 8'h00, 1'b0);
      end
      // requests raised while busy (R8)
      for (int k = 0; k < 8; k++) do_op(1'b0, addr_of(k + 40), 8'h00, 1'b1);
      while (!req_ready) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(n_wr_commit == 256 + 16, "R8 no extra writes", n_wr_commit, 272);
      chk(n_rd_ret == 16 + 256 + 16 + 8, "R3 one pulse per read", n_rd_ret, 296);
      for (int k = 0; k < 256; k++)
         chk(model[k] == shadow[k], "R9 memory contents", int'(model[k]), int'(shadow[k]));
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
   end

endmodule